// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs management read and write frames to an external PHY over the two-wire management clock and data interface. A host places a PHY address, a register address, a read/write flag and write data on its inputs and pulses `start`. The block then runs the whole frame by itself. It produces the management clock from a programmable half-period count of system clocks. It drives or releases the data line through separate enable and data outputs, and it samples the returned line during reads.

Each frame is built from bit slots. In every slot the management clock is low for one half-period and then high for one half-period. The block changes its drive only at the start of a slot, while the clock is low, so the PHY always sees stable data on the rising edge.

On a read, the block checks that the PHY pulls the turnaround bit low. If the PHY leaves the line high, the block abandons the frame and sends 32 released recovery clocks to resynchronise the PHY. It then finishes with an error flag and no data. A single-cycle `done` pulse ends every transaction.

Top module: `mgmt_frame_master`

## Requirements
- R1: At reset and whenever no transaction runs, `mdc_o` is high, `mdio_oe` is low, `busy` is low and `done` is low.
- R2: Every frame opens with 32 clock slots in which `mdio_oe` is 1 and `mdio_o` is 1.
- R3: After the preamble, the block drives the start bits 0 then 1, then the opcode: 1,0 for a read (`rd_req`=1) and 0,1 for a write.
- R4: The 5-bit PHY address and then the 5-bit register address follow, each most significant bit first.
- R5: Each clock slot holds `mdc_o` low for `half_period` system clocks and then high for `half_period` clocks. `mdio_oe` and `mdio_o` never change while `mdc_o` rises or stays high.
- R6: A `half_period` of zero is taken as one system clock.
- R7: A read releases the line from slot 46 onward. It samples `mdio_i` at the end of the high phase of slot 46 (turnaround). It shifts in 16 data bits MSB first from slots 47 to 62 and adds one released slot (63), for 64 slots in all. It then returns `rd_data` with `err`=0.
- R8: If the turnaround sample is 1, the block sends 32 more released slots (79 slots in all). It then sets `err`=1 and `rd_data`=0.
- R9: A write drives turnaround 1,0 in slots 46 and 47 and the data MSB first in slots 48 to 63. It then releases the line for one more slot (65 slots in all). A write leaves `rd_data` unchanged.
- R10: `busy` rises on the clock edge that accepts `start` and stays high until the edge where the single-cycle `done` pulse appears. While busy, `start` and every request input, `half_period` included, are ignored.
- R11: `mdio_oe` is low in every slot in which the PHY owns the line, and it returns low at `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (taken only while idle) |
| rd_req | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| half_period | input | 8 | Clock half-period in system clocks (0 acts as 1) |
| mdio_i | input | 1 | Sampled management data line |
| mdc_o | output | 1 | Management clock |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_o | output | 1 | Data line drive value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Turnaround failure of the last read, held until the next start |
| rd_data | output | 16 | Data of the last successful read |

## Verification
The bench acts as the PHY. It records the drive state at every rising management clock edge and measures the length of every low and high phase. A turnaround failure followed by a clean read shows whether recovery really resynchronises the block; a design that skipped the 32 recovery slots or dropped the error would return garbage as data. A half-period of zero catches a divider that would stall or wrap. A second `start` with changed fields in mid-frame exposes a design that restarts or picks up the new half-period. A write after a read checks that the read data is not overwritten and that the line is released for the closing slot rather than driven into the PHY.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  typedef enum logic [3:0] {
    SEG_IDLE,
    SEG_PRE,
    SEG_SOF,
    SEG_OP,
    SEG_PHY,
    SEG_REG,
    SEG_TA,
    SEG_DATA,
    SEG_TAIL,
    SEG_RECOV
  } seg_e;

  function automatic seg_e seg_after(seg_e s);
    case (s)
      SEG_PRE:  return SEG_SOF;
      SEG_SOF:  return SEG_OP;
      SEG_OP:   return SEG_PHY;
      SEG_PHY:  return SEG_REG;
      SEG_REG:  return SEG_TA;
      SEG_TA:   return SEG_DATA;
      SEG_DATA: return SEG_TAIL;
      default:  return SEG_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/mgmt_half_timer.sv
module mgmt_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] half_period,
  output logic             half_end
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  assign half_end = run && (cnt_q == div_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (load) begin
      div_q <= (half_period == '0) ? DIV_W'(1) : half_period;
      cnt_q <= '0;
    end else if (run) begin
      if (half_end) cnt_q <= '0;
      else          cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // R6
  div_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (div_q != '0));

endmodule

// File: rtl/mgmt_rx_shift.sv
module mgmt_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] word
);

  always_ff @(posedge clk) begin
    if (rst || clr) word <= '0;
    else if (shift) word <= {word[W-2:0], bit_in};
  end

endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import mgmt_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32,
  parameter int RECOV_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              half_end,
  input  logic              mdio_i,
  input  logic [DATA_W-1:0] rx_word,
  output logic              accept,
  output logic              rx_shift,
  output logic              mdc_o,
  output logic              mdio_oe,
  output logic              mdio_o,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data
);

  localparam int TX_W  = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int L1    = (PRE_LEN > RECOV_LEN) ? PRE_LEN : RECOV_LEN;
  localparam int L2    = (L1 > DATA_W) ? L1 : DATA_W;
  localparam int L3    = (L2 > ADDR_W) ? L2 : ADDR_W;
  localparam int IDX_W = $clog2(L3 + 1);

  seg_e              seg_q, seg_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [TX_W-1:0]   tx_q, tx_n;
  logic              phase_hi_q, rd_q;
  logic              mdc_q, oe_q, o_q, busy_q, done_q, err_q;
  logic [DATA_W-1:0] rdata_q;
  logic              slot_end, last_slot, ta_fail, oe_n, o_n;

  function automatic int unsigned seg_len(seg_e s, logic is_rd);
    case (s)
      SEG_PRE:          return PRE_LEN;
      SEG_SOF, SEG_OP:  return 2;
      SEG_PHY, SEG_REG: return ADDR_W;
      SEG_TA:           return is_rd ? 1 : 2;
      SEG_DATA:         return DATA_W;
      SEG_RECOV:        return RECOV_LEN;
      default:          return 1;
    endcase
  endfunction

  assign accept   = start && !busy_q;
  assign slot_end = busy_q && phase_hi_q && half_end;
  assign rx_shift = slot_end && rd_q && (seg_q == SEG_DATA);

  always_comb begin
    last_slot = (idx_q == IDX_W'(seg_len(seg_q, rd_q) - 1));
    ta_fail   = rd_q && (seg_q == SEG_TA) && mdio_i;
    seg_n     = seg_q;
    idx_n     = idx_q;
    if (ta_fail) begin
      seg_n = SEG_RECOV;
      idx_n = '0;
    end else if (last_slot) begin
      seg_n = seg_after(seg_q);
      idx_n = '0;
    end else begin
      idx_n = idx_q + IDX_W'(1);
    end
    tx_n = (seg_q == SEG_PRE) ? tx_q : {tx_q[TX_W-2:0], 1'b0};
    oe_n = (seg_n inside {SEG_PRE, SEG_SOF, SEG_OP, SEG_PHY, SEG_REG}) ||
           (!rd_q && (seg_n inside {SEG_TA, SEG_DATA}));
    o_n  = oe_n && ((seg_n == SEG_PRE) || tx_n[TX_W-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q      <= SEG_IDLE;
      idx_q      <= '0;
      tx_q       <= '0;
      phase_hi_q <= 1'b0;
      rd_q       <= 1'b0;
      mdc_q      <= 1'b1;
      oe_q       <= 1'b0;
      o_q        <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
    end else if (accept) begin
      seg_q      <= SEG_PRE;
      idx_q      <= '0;
      tx_q       <= {2'b01, (rd_req ? 2'b10 : 2'b01), phy_addr, reg_addr, 2'b10, wr_data};
      phase_hi_q <= 1'b0;
      rd_q       <= rd_req;
      mdc_q      <= 1'b0;
      oe_q       <= 1'b1;
      o_q        <= 1'b1;
      busy_q     <= 1'b1;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q && half_end && !phase_hi_q) begin
        phase_hi_q <= 1'b1;
        mdc_q      <= 1'b1;
      end
      if (slot_end) begin
        phase_hi_q <= 1'b0;
        seg_q      <= seg_n;
        idx_q      <= idx_n;
        tx_q       <= tx_n;
        if (seg_n == SEG_IDLE) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          mdc_q  <= 1'b1;
          oe_q   <= 1'b0;
          o_q    <= 1'b0;
          if (seg_q == SEG_RECOV) begin
            err_q   <= 1'b1;
            rdata_q <= '0;
          end else if (rd_q) begin
            rdata_q <= rx_word;
          end
        end else begin
          mdc_q <= 1'b0;
          oe_q  <= oe_n;
          o_q   <= o_n;
        end
      end
    end
  end

  assign mdc_o   = mdc_q;
  assign mdio_oe = oe_q;
  assign mdio_o  = o_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign err     = err_q;
  assign rd_data = rdata_q;

  // R5
  drive_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc_q) |-> ($stable(oe_q) && $stable(o_q)));

  // R5
  drive_while_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc_q && $past(mdc_q)) |-> ($stable(oe_q) && $stable(o_q)));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (mdc_q && !oe_q));

  // R11
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && rd_q && (seg_q inside {SEG_TA, SEG_DATA, SEG_TAIL, SEG_RECOV})) |-> !oe_q);

endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int DIV_W     = 8,
  parameter int PRE_LEN   = 32,
  parameter int RECOV_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              mdio_i,
  output logic              mdc_o,
  output logic              mdio_oe,
  output logic              mdio_o,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data
);

  logic              accept;
  logic              half_end;
  logic              rx_shift;
  logic [DATA_W-1:0] rx_word;

  mgmt_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .load        (accept),
    .run         (busy),
    .half_period (half_period),
    .half_end    (half_end)
  );

  mgmt_rx_shift #(.W(DATA_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .shift  (rx_shift),
    .bit_in (mdio_i),
    .word   (rx_word)
  );

  mgmt_frame_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PRE_LEN   (PRE_LEN),
    .RECOV_LEN (RECOV_LEN)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_req   (rd_req),
    .phy_addr (phy_addr),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .half_end (half_end),
    .mdio_i   (mdio_i),
    .rx_word  (rx_word),
    .accept   (accept),
    .rx_shift (rx_shift),
    .mdc_o    (mdc_o),
    .mdio_oe  (mdio_oe),
    .mdio_o   (mdio_o),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rd_data  (rd_data)
  );

endmodule

// File: tb/test_mgmt_frame_master.sv
module test_mgmt_frame_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_req = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  half_period = 8'd1;
  logic        mdio_i = 1'b1;
  logic        mdc_o, mdio_oe, mdio_o, busy, done, err;
  logic [15:0] rd_data;

  int vectors = 0;
  int miscompares = 0;

  mgmt_frame_master i_mgmt_frame_master (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .half_period(half_period), .mdio_i(mdio_i), .mdc_o(mdc_o),
    .mdio_oe(mdio_oe), .mdio_o(mdio_o), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  // PHY model and monitor state
  logic        mon_on = 1'b0;
  logic        prev_mdc = 1'b1;
  int          n_rise = 0;
  int          lo_run = 0;
  int          hi_run = 0;
  int          exp_h = 1;
  int          phase_bad = 0;
  logic        resp_ta = 1'b0;
  logic [15:0] resp_data = '0;
  logic        bit_oe [0:127];
  logic        bit_o  [0:127];
  logic [15:0] last_rd = '0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (mdc_o != prev_mdc) begin
        if (mdc_o) begin
          if (lo_run != exp_h) phase_bad++;
          if (n_rise < 128) begin
            bit_oe[n_rise] = mdio_oe;
            bit_o[n_rise]  = mdio_o;
          end
          if (n_rise == 46) mdio_i = resp_ta;
          else if (n_rise >= 47 && n_rise <= 62) mdio_i = resp_data[15 - (n_rise - 47)];
          else mdio_i = 1'b1;
          n_rise++;
        end else if (n_rise > 0) begin
          if (hi_run != exp_h) phase_bad++;
        end
        lo_run = 0;
        hi_run = 0;
      end
      if (mdc_o) hi_run++;
      else       lo_run++;
    end else begin
      mdio_i = 1'b1;
    end
    prev_mdc = mdc_o;
  end

  // One transaction with full frame checks
  task automatic run_txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [7:0] hp,
                         input logic ta_high, input logic [15:0] rv, input bit poke);
    logic eoe [0:127];
    logic eo  [0:127];
    int   nexp;
    int   bad_pre, bad_hdr, bad_addr, bad_body, gaps, waited;
    bit   seen_done;
    for (int i = 0; i < 128; i++) begin eoe[i] = 1'b0; eo[i] = 1'b0; end
    for (int i = 0; i < 32; i++) begin eoe[i] = 1'b1; eo[i] = 1'b1; end
    eoe[32] = 1; eo[32] = 0; eoe[33] = 1; eo[33] = 1;
    eoe[34] = 1; eo[34] = rd; eoe[35] = 1; eo[35] = !rd;
    for (int i = 0; i < 5; i++) begin
      eoe[36+i] = 1; eo[36+i] = pa[4-i];
      eoe[41+i] = 1; eo[41+i] = ra[4-i];
    end
    if (rd) nexp = ta_high ? 79 : 64;
    else begin
      nexp = 65;
      eoe[46] = 1; eo[46] = 1; eoe[47] = 1; eo[47] = 0;
      for (int i = 0; i < 16; i++) begin eoe[48+i] = 1; eo[48+i] = wd[15-i]; end
    end

    @(negedge clk);
    rd_req = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; half_period = hp;
    exp_h = (hp == 0) ? 1 : int'(hp);
    resp_ta = ta_high; resp_data = rv;
    n_rise = 0; phase_bad = 0; lo_run = 0; hi_run = 0;
    for (int i = 0; i < 128; i++) begin bit_oe[i] = 1'bx; bit_o[i] = 1'bx; end
    mon_on = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10 busy after accept", int'(busy), 1);
    gaps = 0; waited = 0; seen_done = 0;
    while (!seen_done && waited < 40000) begin
      if (poke && waited == 9) begin
        // R10: a second request while busy must be ignored
        start = 1'b1; rd_req = !rd; phy_addr = ~pa; half_period = hp + 8'd3;
      end else begin
        start = 1'b0;
      end
      if (done === 1'b1) seen_done = 1;
      else begin
        if (busy !== 1'b1) gaps++;
        @(negedge clk);
        waited++;
      end
    end
    start = 1'b0;
    chk(seen_done, "R10 done seen", int'(seen_done), 1);
    chk(gaps == 0, "R10 busy held until done", gaps, 0);
    chk(busy === 1'b0, "R10 busy low at done", int'(busy), 0);
    if (rd) begin
      if (ta_high) begin
        chk(err === 1'b1, "R8 error flag", int'(err), 1);
        chk(rd_data === 16'h0000, "R8 no data", int'(rd_data), 0);
        last_rd = 16'h0000;
      end else begin
        chk(err === 1'b0, "R7 error clear", int'(err), 0);
        chk(rd_data === rv, "R7 read data", int'(rd_data), int'(rv));
        last_rd = rv;
      end
    end else begin
      chk(err === 1'b0, "R9 error clear", int'(err), 0);
      chk(rd_data === last_rd, "R9 read data kept", int'(rd_data), int'(last_rd));
    end
    @(negedge clk);
    chk(done === 1'b0, "R10 done single cycle", int'(done), 0);
    chk(mdc_o === 1'b1 && mdio_oe === 1'b0, "R11 idle release", int'({mdc_o, mdio_oe}), 2);
    mon_on = 1'b0;

    chk(n_rise == nexp, rd ? (ta_high ? "R8 slot count" : "R7 slot count") : "R9 slot count", n_rise, nexp);
    chk(phase_bad == 0, hp == 0 ? "R6 zero half-period" : "R5 phase length", phase_bad, 0);
    bad_pre = 0; bad_hdr = 0; bad_addr = 0; bad_body = 0;
    for (int s = 0; s < nexp && s < 128; s++) begin
      bit mism;
      mism = (bit_oe[s] !== eoe[s]) || (eoe[s] && (bit_o[s] !== eo[s]));
      if (mism) begin
        if (s < 32) bad_pre++;
        else if (s < 36) bad_hdr++;
        else if (s < 46) bad_addr++;
        else bad_body++;
      end
    end
    chk(bad_pre == 0, "R2 preamble", bad_pre, 0);
    chk(bad_hdr == 0, "R3 start and opcode", bad_hdr, 0);
    chk(bad_addr == 0, "R4 addresses", bad_addr, 0);
    chk(bad_body == 0, rd ? "R11 read release" : "R9 write body", bad_body, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(mdc_o === 1'b1, "R1 mdc idle high", int'(mdc_o), 1);
    chk(mdio_oe === 1'b0, "R1 oe low", int'(mdio_oe), 0);
    chk(busy === 1'b0 && done === 1'b0, "R1 busy and done low", int'({busy, done}), 0);
  endtask

  task automatic test_read_basic();
    run_txn(1'b1, 5'h15, 5'h0A, 16'h0000, 8'd2, 1'b0, 16'hA55A, 1'b0);
  endtask

  task automatic test_read_fast();
    run_txn(1'b1, 5'h01, 5'h1F, 16'h0000, 8'd1, 1'b0, 16'h8001, 1'b0);
  endtask

  task automatic test_write();
    run_txn(1'b0, 5'h1E, 5'h03, 16'hC3E1, 8'd3, 1'b0, 16'h0000, 1'b0);
  endtask

  task automatic test_ta_fail_then_recover();
    run_txn(1'b1, 5'h07, 5'h11, 16'h0000, 8'd2, 1'b1, 16'h1234, 1'b0);
    run_txn(1'b1, 5'h07, 5'h11, 16'h0000, 8'd2, 1'b0, 16'h7FFE, 1'b0);
  endtask

  task automatic test_zero_half();
    run_txn(1'b0, 5'h10, 5'h08, 16'h5A0F, 8'd0, 1'b0, 16'h0000, 1'b0);
  endtask

  task automatic test_busy_ignore();
    run_txn(1'b1, 5'h0C, 5'h15, 16'hFFFF, 8'd2, 1'b0, 16'h3C96, 1'b1);
  endtask

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_read_basic();
    test_read_fast();
    test_write();
    test_ta_fail_then_recover();
    test_zero_half();
    test_busy_ignore();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule